// File: doc/BRIEF.md
# Clock-Generator Configuration Register Target on I2C

This block is an I2C target that keeps a small configuration store for a clock generator: eight bytes that together form a 64-bit parallel control word. A bus master reaches the store through the usual two-wire protocol. The target answers a 7-bit device address whose upper five bits are fixed and whose two lowest bits come from strap pins, so four copies can share a bus. SCL and SDA are brought into the system clock domain through a short synchroniser. Edges, START and STOP are then detected on the synchronised copies. The target drives SDA only through an open-drain enable output.

After a write-direction address, the first byte the master sends sets an internal register pointer. Each further byte is stored at the pointer, and the pointer then advances. A read-direction address, usually sent after a repeated START, streams bytes from the current pointer until the master answers a byte with no acknowledge. The pointer wraps inside the eight registers in both directions. A byte is committed at the moment the target acknowledges it, so a long sequential write updates the control word one byte at a time before the STOP arrives. The block has no data stream of its own: the bus is the only transfer path, so no valid/ready handshake or back-pressure applies, and the strap and control-word pins are plain levels.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal binary 10110 followed by addr_strap[1] and then addr_strap[0]. Bit 0 of the address byte selects read (1) or write (0).
- R2: The general-call address (seven zero bits) is never acknowledged, and SDA is not driven in response to it.
- R3: The first data byte after a write-direction address loads the pointer from its low three bits. The pointer keeps that value across a STOP, so a later read starts from it.
- R4: The pointer advances by one after every data byte written or read, and it wraps from register 7 to register 0.
- R5: A written byte appears on cfg_bits no later than the end of its acknowledge bit, before any STOP.
- R6: A STOP or repeated START that arrives in the middle of a data byte discards the received bits, and no register changes.
- R7: A read returns register bytes from the current pointer, most significant bit first, and continues while the master acknowledges. After the master sends no acknowledge, the target leaves SDA released.
- R8: After reset every register is zero, and every bit written reads back unchanged, including the all-ones and all-zeros patterns.
- R9: A falling SDA while SCL is high is START and a rising SDA while SCL is high is STOP. The target changes its SDA drive only while SCL is low.
- R10: After an address that does not match, the target ignores all bus traffic, acknowledging nothing and driving nothing, until the next START or STOP.
- R11: Register k occupies cfg_bits[8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus (at least ten times the SCL rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the SCL bus line |
| sda_i | input | 1 | Level of the SDA bus line (wired value) |
| addr_strap | input | 2 | Two low bits of the device address |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_bits | output | 64 | Parallel view of the eight configuration registers |

## Verification
The embedded properties check, cycle by cycle, that SDA drive changes only while the synchronised SCL is low, that the target is silent while idle or ignoring traffic, that each committed write is accompanied by an acknowledge and lands in the addressed register, that registers hold when nothing writes them, that a STOP returns the target to idle and that the pointer wraps after the last register. What only the bench scenarios show is the end-to-end protocol: the full sweep of device addresses against the straps, pointer persistence between transactions, the order of bytes in sequential reads and writes across the wrap, and the discarding of bytes cut short by STOP or repeated START.

// File: rtl/clkcfg_i2c_pkg.sv
package clkcfg_i2c_pkg;

  // Protocol engine states
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_RX,     // shifting in a byte from the master
    ST_ACK,    // target holds SDA low for the acknowledge bit
    ST_TX,     // shifting out a byte to the master
    ST_MACK,   // master acknowledge slot after a transmitted byte
    ST_SKIP    // not addressed, or read ended: silent until START/STOP
  } ctl_state_e;

  // Meaning of the byte being received
  typedef enum logic [1:0] {
    RX_ADDR,
    RX_PTR,
    RX_DATA
  } rx_kind_e;

  // Fixed upper part of the 7-bit device address
  localparam logic [4:0] DEV_ID_HI = 5'b10110;

endpackage

// File: rtl/clkcfg_i2c_sync.sv
module clkcfg_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  // Idle bus level is high, so every stage resets to one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
      sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
      scl_d    <= scl_pipe[LAST];
      sda_d    <= sda_pipe[LAST];
    end
  end

  assign scl_q     = scl_pipe[LAST];
  assign sda_q     = sda_pipe[LAST];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // SDA moving while SCL stays high marks a bus condition (R9)
  assign bus_start = scl_q & scl_d & sda_d & ~sda_q;
  assign bus_stop  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/clkcfg_i2c_regs.sv
module clkcfg_i2c_regs #(
  parameter int NREG  = 8,
  parameter int DW    = 8,
  parameter int PTR_W = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PTR_W-1:0]     wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [PTR_W-1:0]     rd_idx,
  output logic [DW-1:0]        rd_data,
  output logic [NREG*DW-1:0]   cfg_flat
);

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (wr_en && (wr_idx == PTR_W'(g)))
        regs_q[g] <= wr_data;
    end
    // Register g occupies its own byte lane of the control word (R11)
    assign cfg_flat[g*DW +: DW] = regs_q[g];
  end

  assign rd_data = regs_q[rd_idx];

  // Control word holds while nothing is committed (R5, R6)
  p_hold_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_flat));

  // A commit lands exactly in the addressed register (R8)
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/clkcfg_i2c_ctrl.sv
module clkcfg_i2c_ctrl
  import clkcfg_i2c_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DW    = 8,
  parameter int PTR_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_q,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic [6:0]       dev_addr,
  input  logic [DW-1:0]    rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic [PTR_W-1:0] rd_idx
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NREG - 1);
  localparam int               CNT_W    = $clog2(DW);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DW - 1);

  ctl_state_e       st;
  rx_kind_e         kind;
  logic [CNT_W-1:0] bit_cnt;
  logic [DW-1:0]    rx_sh;
  logic [DW-1:0]    tx_sh;
  logic             byte_done;
  logic             is_read;
  logic             mack_ok;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptr_next;
  logic             no_cond;
  logic             rx_close;

  assign ptr_next = (ptr == PTR_LAST) ? '0 : ptr + PTR_W'(1);
  assign no_cond  = !bus_start && !bus_stop;
  // A full byte has been shifted in and SCL has just dropped: the acknowledge bit begins
  assign rx_close = (st == ST_RX) && scl_fall && byte_done && no_cond;

  // Commit happens on the very edge at which the acknowledge is driven (R5)
  assign wr_en   = rx_close && (kind == RX_DATA);
  assign wr_idx  = ptr;
  assign wr_data = rx_sh;
  assign rd_idx  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= RX_ADDR;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      byte_done <= 1'b0;
      is_read   <= 1'b0;
      mack_ok   <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
    end else if (bus_stop) begin
      // Any byte in flight is dropped (R6)
      st        <= ST_IDLE;
      byte_done <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (bus_start) begin
      st        <= ST_RX;
      kind      <= RX_ADDR;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && !byte_done) begin
            rx_sh   <= {rx_sh[DW-2:0], sda_q};
            bit_cnt <= bit_cnt + CNT_W'(1);
            if (bit_cnt == CNT_LAST) byte_done <= 1'b1;
          end else if (rx_close) begin
            byte_done <= 1'b0;
            unique case (kind)
              RX_ADDR: begin
                if (rx_sh[DW-1:1] == dev_addr) begin
                  sda_oe  <= 1'b1;
                  is_read <= rx_sh[0];
                  st      <= ST_ACK;
                end else begin
                  st <= ST_SKIP;  // R2, R10
                end
              end
              RX_PTR: begin
                ptr    <= rx_sh[PTR_W-1:0];  // R3
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end
              default: begin
                ptr    <= ptr_next;          // R4
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end
            endcase
          end
        end

        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (is_read && kind == RX_ADDR) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              st     <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_RX;
              kind   <= (kind == RX_ADDR) ? RX_PTR : RX_DATA;
            end
          end
        end

        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == CNT_LAST) begin
              sda_oe <= 1'b0;
              ptr    <= ptr_next;            // R4
              st     <= ST_MACK;
            end else begin
              tx_sh   <= {tx_sh[DW-2:0], 1'b0};
              sda_oe  <= ~tx_sh[DW-2];
              bit_cnt <= bit_cnt + CNT_W'(1);
            end
          end
        end

        ST_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_q;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (mack_ok) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              st     <= ST_TX;
            end else begin
              st <= ST_SKIP;                 // R7: SDA stays released
            end
          end
        end

        default: ;  // ST_IDLE, ST_SKIP wait for a bus condition
      endcase
    end
  end

  // SDA drive moves only while SCL is low (R9)
  p_sda_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q);

  // Silent while idle or ignoring the bus (R10)
  p_quiet_when_skipping_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_SKIP) |-> !sda_oe);

  // Each committed byte is acknowledged (R5)
  p_commit_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // Pointer wraps to register 0 after the last register (R4)
  p_ptr_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == PTR_LAST) |=> (ptr == '0));

  // STOP abandons everything and frees SDA (R6)
  p_stop_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (st == ST_IDLE && !sda_oe));

endmodule

// File: rtl/clkcfg_i2c_target.sv
module clkcfg_i2c_target
  import clkcfg_i2c_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [1:0]           addr_strap,
  output logic                 sda_oe,
  output logic [NREG*DW-1:0]   cfg_bits
);

  localparam int PTR_W = $clog2(NREG);

  logic             scl_q, sda_q, scl_rise, scl_fall, bus_start, bus_stop;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic [DW-1:0]    wr_data, rd_data;
  logic [6:0]       dev_addr;

  assign dev_addr = {DEV_ID_HI, addr_strap};  // R1

  clkcfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  clkcfg_i2c_ctrl #(.NREG(NREG), .DW(DW), .PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx)
  );

  clkcfg_i2c_regs #(.NREG(NREG), .DW(DW), .PTR_W(PTR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .cfg_flat (cfg_bits)
  );

endmodule

// File: tb/clkcfg_i2c_target_tb.sv
module clkcfg_i2c_target_tb;

  localparam int HALF = 16;  // SCL high/low time in system clocks
  localparam int QTR  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  strap = 2'b10;
  logic        sda_oe;
  logic [63:0] cfg_bits;
  logic        sda_line;

  int checks = 0;
  int errors = 0;
  int r9_bad = 0;
  logic [7:0] model [8];
  int ptr_m = 0;
  logic prev_oe = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;  // wired-AND bus

  clkcfg_i2c_target u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .addr_strap (strap),
    .sda_oe     (sda_oe),
    .cfg_bits   (cfg_bits)
  );

  // R9 monitor: target drive must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_m) r9_bad++;
    prev_oe <= sda_oe;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[k*8 +: 8] = model[k];
    return f;
  endfunction

  function automatic logic [7:0] dev(input logic [1:0] s, input bit rd);
    return {5'b10110, s, rd};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wclk(QTR);
    scl_m = 1'b1; wclk(QTR);
    sda_m = 1'b0; wclk(QTR);
    scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(QTR);
    scl_m = 1'b1; wclk(QTR);
    sda_m = 1'b1; wclk(HALF);
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; wclk(QTR);
    scl_m = 1'b1; wclk(HALF);
    scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wclk(QTR);
    scl_m = 1'b1; wclk(HALF/2);
    b = sda_line;
    wclk(HALF/2);
    scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic put_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!give_ack);
  endtask

  // Sequential write of n bytes starting at pointer p, value v0 + i*step
  task automatic wr_seq(input int p, input int n, input logic [7:0] v0, input logic [7:0] step);
    bit a;
    logic [7:0] v;
    bus_start();
    put_byte(dev(strap, 1'b0), a);
    put_byte(8'(p), a);
    ptr_m = p % 8;
    for (int i = 0; i < n; i++) begin
      v = v0 + 8'(i) * step;
      put_byte(v, a);
      chk(a, "R4 write byte ack", 64'(a), 64'd1);
      model[ptr_m] = v;
      ptr_m = (ptr_m + 1) % 8;
      // R5: visible at end of acknowledge, before STOP
      chk(cfg_bits == model_flat(), "R5 R11 commit before STOP", cfg_bits, model_flat());
    end
    bus_stop();
  endtask

  // Sequential read of n bytes from pointer p
  task automatic rd_seq(input int p, input int n);
    bit a;
    logic [7:0] d;
    bus_start();
    put_byte(dev(strap, 1'b0), a);
    put_byte(8'(p), a);
    ptr_m = p % 8;
    bus_start();
    put_byte(dev(strap, 1'b1), a);
    chk(a, "R1 read address ack", 64'(a), 64'd1);
    for (int i = 0; i < n; i++) begin
      get_byte(d, i != n - 1);
      chk(d == model[ptr_m], "R7 R8 read data", d, model[ptr_m]);
      ptr_m = (ptr_m + 1) % 8;
    end
    wclk(QTR);
    chk(sda_oe == 1'b0, "R7 SDA released after no-ack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin : main
    bit a;
    logic [7:0] d;
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);

    // R8 reset state
    chk(cfg_bits == 64'd0, "R8 reset registers zero", cfg_bits, 0);
    chk(sda_oe == 1'b0, "R8 reset SDA released", sda_oe, 0);

    // R1 R2 R10: sweep every 7-bit address
    for (int ad = 0; ad < 128; ad++) begin
      bit exp_ack;
      exp_ack = (ad == {5'b10110, strap});
      bus_start();
      put_byte({7'(ad), 1'b0}, a);
      if (ad == 0) chk(a == 1'b0, "R2 general call ignored", 64'(a), 0);
      else chk(a == exp_ack, "R1 address match", 64'(a), 64'(exp_ack));
      if (!exp_ack) begin
        put_byte(8'h00, a);
        chk(a == 1'b0, "R10 traffic after mismatch ignored", 64'(a), 0);
        chk(sda_oe == 1'b0, "R10 no drive after mismatch", sda_oe, 0);
      end
      bus_stop();
    end

    // R1 strap dependence
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      wclk(4);
      bus_start();
      put_byte(dev(2'(s), 1'b0), a);
      bus_stop();
      chk(a, "R1 strap address ack", 64'(a), 1);
      bus_start();
      put_byte(dev(2'(s) ^ 2'b01, 1'b0), a);
      bus_stop();
      chk(!a, "R1 wrong strap nack", 64'(a), 0);
    end
    strap = 2'b10;
    wclk(4);

    // R5 R11: fill all registers, then wrap through the end (R4)
    wr_seq(0, 8, 8'h05, 8'h25);
    wr_seq(6, 10, 8'h91, 8'h13);

    // R8 boundary patterns
    wr_seq(2, 1, 8'hFF, 8'h00);
    wr_seq(3, 1, 8'h00, 8'h00);

    // R7 random reads at every pointer
    for (int p = 0; p < 8; p++) rd_seq(p, 1);
    // R4 R7 sequential read across the wrap
    rd_seq(5, 10);

    // R3: pointer from low three bits persists across STOP
    bus_start();
    put_byte(dev(strap, 1'b0), a);
    put_byte(8'h0B, a);
    bus_stop();
    bus_start();
    put_byte(dev(strap, 1'b1), a);
    get_byte(d, 1'b0);
    bus_stop();
    chk(d == model[3], "R3 pointer kept across STOP", d, model[3]);

    // R6: partial byte ended by STOP
    bus_start();
    put_byte(dev(strap, 1'b0), a);
    put_byte(8'h02, a);
    for (int i = 0; i < 4; i++) put_bit(i[0]);
    bus_stop();
    chk(cfg_bits == model_flat(), "R6 partial byte at STOP dropped", cfg_bits, model_flat());

    // R6: partial byte ended by repeated START, then a valid write
    bus_start();
    put_byte(dev(strap, 1'b0), a);
    put_byte(8'h04, a);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    bus_start();
    chk(cfg_bits == model_flat(), "R6 partial byte at repeated START dropped", cfg_bits, model_flat());
    put_byte(dev(strap, 1'b0), a);
    chk(a, "R9 repeated START recognised", 64'(a), 1);
    put_byte(8'h04, a);
    put_byte(8'h3C, a);
    model[4] = 8'h3C;
    bus_stop();
    chk(cfg_bits == model_flat(), "R6 write after aborted byte", cfg_bits, model_flat());

    chk(r9_bad == 0, "R9 SDA drive moved while SCL high", 64'(r9_bad), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    wclk(190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule